// File: doc/BRIEF.md
# S/PDIF Channel Status Capture Unit

This unit sits behind a biphase decoder and preamble detector. Each clock in which `sf_valid` is high presents one decoded subframe: which channel it belongs to, whether it opens a new 192-frame block, its recovered channel-status (C) bit and its 24-bit audio word. The stream is treated as stereo, so the unit collects C bits from first-channel subframes only. It keeps the first forty bits of each block as five status bytes that software can read. An update flag marks when a complete set has been stored.

Two control outputs are decoded from the stored bytes. The first is a de-emphasis enable for the DAC playback path. The second is a word-length mask. The mask trims the audio word sent to the audio interface, clearing the low bits that the source marked as unused. A second audio output carries the untouched 24-bit word for retransmission. Both audio outputs are registered and follow each subframe event by one clock.

Top module: `spdif_cs_capture`

## Requirements
- R1: C bits of second-channel subframes (`sf_second`=1) never affect the stored status bytes; only first-channel subframes (`sf_second`=0) contribute.
- R2: Status bit n of a block (n = 0 on the first-channel subframe with `sf_blk_start`=1, counting up by one per first-channel subframe) is stored at `cs_bytes[n]` for n in 0..39, so byte k bit j holds status bit 8k+j. First-channel subframes seen before any block start are ignored.
- R3: The five status bytes change only together, on the clock edge that captures status bit 39. Until then they keep their previous contents.
- R4: `cs_update` goes high in the cycle after status bit 39 of a block is captured.
- R5: `cs_update` goes low in the cycle after the next first-channel subframe that has `sf_blk_start`=1. Status bits 40 to 191 change neither the bytes nor the flag.
- R6: If a new block starts before status bit 39 has been captured, the partial capture is dropped and the bytes and the flag stay as they were.
- R7: `deemph_en` is high exactly when `dac_sel`=1 and stored bits 3, 4, 5 equal 1, 0, 0 (50/15 us pre-emphasis). It responds combinationally to `dac_sel`.
- R8: Let code = bit33 + 2*bit34 + 4*bit35. When bit32=1 (24-bit maximum), codes 1, 2, 4, 5, 6 give lengths 20, 22, 23, 24, 21. When bit32=0 (20-bit maximum), the same codes give 16, 18, 19, 20, 17. `wl_mask` has its top `length` bits set, and `aif_audio` equals the word ANDed with the mask.
- R9: Codes 0, 3 and 7 give the full 24-bit length (mask all ones). This is also the state after reset.
- R10: One cycle after each subframe event, `tx_audio` holds that event's full 24-bit word and `aif_audio` holds its masked copy. Both outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | A decoded subframe is present this cycle |
| sf_second | input | 1 | 0 = first channel, 1 = second channel |
| sf_blk_start | input | 1 | Subframe carries the block-start preamble |
| sf_cbit | input | 1 | Recovered channel-status bit |
| sf_audio | input | 24 | Recovered audio word |
| dac_sel | input | 1 | DAC playback path uses the received stream |
| cs_bytes | output | 40 | Five stored status bytes, byte k at bits 8k+7..8k |
| cs_update | output | 1 | Status bytes hold a complete capture |
| deemph_en | output | 1 | De-emphasis enable for the DAC path |
| wl_mask | output | 24 | Word-length mask applied to the audio interface copy |
| aif_audio | output | 24 | Truncated audio word for the audio interface |
| tx_audio | output | 24 | Full-width audio word for retransmission |

## Verification
The assertions assume the upstream decoder marks a block start only on first-channel subframes. They also assume it never delivers a block start less than forty first-channel subframes after the previous one, unless that block is meant to be abandoned. From these assumptions they take the rule that a change in the stored bytes always comes with a rising update flag, and that the flag falls only after a first-channel block start. The stimulus alternates first- and second-channel subframes and places block-start flags only on first-channel subframes. Each second-channel C bit is the inverse of its first-channel partner, so that any leak into the stored bytes shows up.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

   // Audio word width carried by each subframe.
   localparam int unsigned SF_AUDIO_W = 24;

   // Word-length lookup from the stored status bits.
   // code = {bit35, bit34, bit33}; max24 = bit32.
   function automatic int unsigned wl_bits(input logic max24,
                                           input logic [2:0] code,
                                           input int unsigned full);
      int unsigned r;
      case (code)
         3'd1:    r = max24 ? 20 : 16;
         3'd2:    r = max24 ? 22 : 18;
         3'd4:    r = max24 ? 23 : 19;
         3'd5:    r = max24 ? 24 : 20;
         3'd6:    r = max24 ? 21 : 17;
         default: r = full;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cs_collect.sv
module cs_collect #(
   parameter int unsigned CS_BYTES  = 5,
   parameter int unsigned BLOCK_LEN = 192
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_second,
   input  logic                  in_blk,
   input  logic                  in_cbit,
   output logic [CS_BYTES*8-1:0] cs_regs,
   output logic                  cs_upd
);
   localparam int unsigned CS_BITS = CS_BYTES * 8;
   localparam int unsigned IDX_W   = $clog2(BLOCK_LEN + 1);
   localparam int unsigned SH_W    = $clog2(CS_BITS);

   if (CS_BITS < 36) begin : g_bad_bytes
      $error("cs_collect: status store must reach bit 35");
   end
   if (BLOCK_LEN <= CS_BITS) begin : g_bad_len
      $error("cs_collect: block must be longer than the stored bits");
   end

   logic [IDX_W-1:0]   idx;
   logic               armed;
   logic [CS_BITS-1:0] shadow;
   logic [CS_BITS-1:0] shadow_nx;
   logic               ch1_evt;
   logic               in_store;
   logic               last_bit;

   assign ch1_evt  = in_valid && !in_second;
   assign in_store = (idx < IDX_W'(CS_BITS));
   assign last_bit = (idx == IDX_W'(CS_BITS - 1));

   always_comb begin
      shadow_nx = shadow;
      if (in_store) begin
         shadow_nx[idx[SH_W-1:0]] = in_cbit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx     <= '0;
         armed   <= 1'b0;
         shadow  <= '0;
         cs_regs <= '0;
         cs_upd  <= 1'b0;
      end else if (ch1_evt) begin
         if (in_blk) begin
            shadow    <= '0;
            shadow[0] <= in_cbit;
            idx       <= IDX_W'(1);
            armed     <= 1'b1;
            cs_upd    <= 1'b0;
         end else if (armed && (idx < IDX_W'(BLOCK_LEN))) begin
            shadow <= shadow_nx;
            idx    <= idx + 1'b1;
            if (last_bit) begin
               cs_regs <= shadow_nx;
               cs_upd  <= 1'b1;
            end
         end
      end
   end

   // R3
   cs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_regs != $past(cs_regs)) |-> $rose(cs_upd));

   // R5
   upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_upd) |-> $past(in_valid && !in_second && in_blk));

   // R1
   second_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_second) |=> $stable(cs_regs));

   // R5
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_W'(BLOCK_LEN));

endmodule

// File: rtl/cs_decode.sv
module cs_decode
   import spdif_cs_pkg::*;
#(
   parameter int unsigned CS_BITS = 40,
   parameter int unsigned AUDIO_W = SF_AUDIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CS_BITS-1:0] cs_regs,
   input  logic               dac_sel,
   output logic               deemph_en,
   output logic [AUDIO_W-1:0] wl_mask
);
   localparam int unsigned LEN_W = $clog2(AUDIO_W + 1);

   if (AUDIO_W < 24) begin : g_bad_w
      $error("cs_decode: audio word must be at least 24 bits");
   end

   logic [LEN_W-1:0] wl_len;
   logic [LEN_W-1:0] drop;

   assign deemph_en = dac_sel && cs_regs[3] && !cs_regs[4] && !cs_regs[5];
   assign wl_len    = LEN_W'(wl_bits(cs_regs[32], cs_regs[35:33], AUDIO_W));
   assign drop      = LEN_W'(AUDIO_W) - wl_len;

   for (genvar i = 0; i < AUDIO_W; i++) begin : g_mask
      assign wl_mask[i] = (LEN_W'(i) >= drop);
   end

   // R7
   deemph_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deemph_en |-> dac_sel);

   // R8
   mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wl_mask) >= 16);

endmodule

// File: rtl/audio_path.sv
module audio_path #(
   parameter int unsigned AUDIO_W = 24,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [AUDIO_W-1:0] in_audio,
   input  logic [AUDIO_W-1:0] mask,
   output logic [AUDIO_W-1:0] aif_audio,
   output logic [AUDIO_W-1:0] tx_audio
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            aif_audio <= '0;
            tx_audio  <= '0;
         end else if (in_valid) begin
            aif_audio <= in_audio & mask;
            tx_audio  <= in_audio;
         end
      end
   end else begin : g_comb
      assign aif_audio = in_audio & mask;
      assign tx_audio  = in_audio;
   end

   // R10
   aif_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aif_audio & ~tx_audio) == '0);

endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
   import spdif_cs_pkg::*;
#(
   parameter int unsigned CS_BYTES  = 5,
   parameter int unsigned BLOCK_LEN = 192,
   parameter int unsigned AUDIO_W   = SF_AUDIO_W,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sf_valid,
   input  logic                  sf_second,
   input  logic                  sf_blk_start,
   input  logic                  sf_cbit,
   input  logic [AUDIO_W-1:0]    sf_audio,
   input  logic                  dac_sel,
   output logic [CS_BYTES*8-1:0] cs_bytes,
   output logic                  cs_update,
   output logic                  deemph_en,
   output logic [AUDIO_W-1:0]    wl_mask,
   output logic [AUDIO_W-1:0]    aif_audio,
   output logic [AUDIO_W-1:0]    tx_audio
);
   localparam int unsigned CS_BITS = CS_BYTES * 8;

   cs_collect #(
      .CS_BYTES  (CS_BYTES),
      .BLOCK_LEN (BLOCK_LEN)
   ) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sf_valid),
      .in_second (sf_second),
      .in_blk    (sf_blk_start),
      .in_cbit   (sf_cbit),
      .cs_regs   (cs_bytes),
      .cs_upd    (cs_update)
   );

   cs_decode #(
      .CS_BITS (CS_BITS),
      .AUDIO_W (AUDIO_W)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_regs   (cs_bytes),
      .dac_sel   (dac_sel),
      .deemph_en (deemph_en),
      .wl_mask   (wl_mask)
   );

   audio_path #(
      .AUDIO_W (AUDIO_W),
      .REG_OUT (REG_OUT)
   ) u_audio (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sf_valid),
      .in_audio  (sf_audio),
      .mask      (wl_mask),
      .aif_audio (aif_audio),
      .tx_audio  (tx_audio)
   );

endmodule

// File: tb/spdif_cs_capture_bench.sv
`timescale 1ns/1ps
module spdif_cs_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sf_valid = 1'b0;
   logic        sf_second = 1'b0;
   logic        sf_blk_start = 1'b0;
   logic        sf_cbit = 1'b0;
   logic [23:0] sf_audio = '0;
   logic        dac_sel = 1'b1;
   logic [39:0] cs_bytes;
   logic        cs_update;
   logic        deemph_en;
   logic [23:0] wl_mask;
   logic [23:0] aif_audio;
   logic [23:0] tx_audio;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   logic [47:0] sb_q[$];

   logic [39:0] exp_cs = '0;
   logic        exp_upd = 1'b0;
   logic [39:0] b_sh = '0;
   int          b_idx = 0;
   logic        b_arm = 1'b0;

   always #5 clk = ~clk;

   spdif_cs_capture u_spdif_cs_capture (
      .clk          (clk),
      .rst_n        (rst_n),
      .sf_valid     (sf_valid),
      .sf_second    (sf_second),
      .sf_blk_start (sf_blk_start),
      .sf_cbit      (sf_cbit),
      .sf_audio     (sf_audio),
      .dac_sel      (dac_sel),
      .cs_bytes     (cs_bytes),
      .cs_update    (cs_update),
      .deemph_en    (deemph_en),
      .wl_mask      (wl_mask),
      .aif_audio    (aif_audio),
      .tx_audio     (tx_audio)
   );

   function automatic logic [23:0] mask_of(input logic [39:0] cs);
      int len;
      logic [2:0] code;
      logic [23:0] m;
      code = {cs[35], cs[34], cs[33]};
      case (code)
         3'd1: len = cs[32] ? 20 : 16;
         3'd2: len = cs[32] ? 22 : 18;
         3'd4: len = cs[32] ? 23 : 19;
         3'd5: len = cs[32] ? 24 : 20;
         3'd6: len = cs[32] ? 21 : 17;
         default: len = 24;
      endcase
      m = '0;
      for (int i = 0; i < 24; i++) m[i] = (i >= 24 - len);
      return m;
   endfunction

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ev(input logic ch, input logic blk, input logic cb, input logic [23:0] a);
      @(negedge clk);
      sf_valid     = 1'b1;
      sf_second    = ch;
      sf_blk_start = blk;
      sf_cbit      = cb;
      sf_audio     = a;
      sb_q.push_back({a & mask_of(exp_cs), a});
      if (!ch) begin
         if (blk) begin
            b_sh = '0; b_sh[0] = cb; b_idx = 1; b_arm = 1'b1; exp_upd = 1'b0;
         end else if (b_arm && b_idx < 192) begin
            if (b_idx < 40) b_sh[b_idx] = cb;
            if (b_idx == 39) begin exp_cs = b_sh; exp_upd = 1'b1; end
            b_idx++;
         end
      end
   endtask

   task automatic idle();
      @(negedge clk);
      sf_valid = 1'b0;
      sf_blk_start = 1'b0;
      @(negedge clk);
   endtask

   task automatic frames(input logic [39:0] pat, input int from, input int upto, input logic allow_blk);
      for (int f = from; f <= upto; f++) begin
         logic c1;
         c1 = (f < 40) ? pat[f] : ((f % 3) == 0);
         ev(1'b0, allow_blk && (f == 0), c1, 24'h5A3C71 ^ 24'(f * 24'h013579));
         ev(1'b1, 1'b0, ~c1, 24'hC3E18F ^ 24'(f * 24'h02468B));
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " bytes"}, {8'h0, cs_bytes}, {8'h0, exp_cs});
      chk({req, " update"}, {47'h0, cs_update}, {47'h0, exp_upd});
   endtask

   // Scoreboard monitor: R8, R10 audio outputs one cycle after each event
   initial begin
      forever begin
         logic v;
         logic [47:0] e;
         @(posedge clk);
         v = sf_valid && rst_n;
         #3;
         if (v) begin
            if (sb_q.size() == 0) begin
               chk("R10 queue", 48'h1, 48'h0);
            end else begin
               e = sb_q.pop_front();
               chk("R10/R8 audio", {aif_audio, tx_audio}, e);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   localparam logic [39:0] PA = 40'h23_9C_4E_B2_08;
   localparam logic [39:0] PC = 40'h04_11_22_33_18;
   localparam logic [39:0] PD = 40'h07_AA_55_0F_F0;
   localparam logic [39:0] PE = 40'h0A_6B_19_D4_08;
   localparam logic [39:0] PF = 40'h01_F0_0F_F0_00;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R9 reset state
      chk_state("R2 reset");
      chk("R7 reset deemph", {47'h0, deemph_en}, 48'h0);
      chk("R9 reset mask", {24'h0, wl_mask}, {24'h0, 24'hFFFFFF});
      chk("R10 reset audio", {aif_audio, tx_audio}, 48'h0);

      // R2: bits before any block start ignored
      frames(40'hFF_FFFF_FFFF, 1, 10, 1'b0);
      idle();
      chk_state("R2 pre-block");

      // Block A: up to bit 38, then bit 39
      frames(PA, 0, 38, 1'b1);
      idle();
      chk_state("R3 before bit39");
      frames(PA, 39, 39, 1'b1);
      idle();
      chk("R1 R2 bytes", {8'h0, cs_bytes}, {8'h0, PA});
      chk("R4 update", {47'h0, cs_update}, 48'h1);
      chk("R7 deemph on", {47'h0, deemph_en}, 48'h1);
      chk("R8 mask 20", {24'h0, wl_mask}, {24'h0, 24'hFFFFF0});
      dac_sel = 1'b0;
      #1;
      chk("R7 dac off", {47'h0, deemph_en}, 48'h0);
      dac_sel = 1'b1;

      // R5: rest of block does not disturb
      frames(PA, 40, 191, 1'b1);
      idle();
      chk_state("R5 tail");

      // Block B: partial, then new start
      frames(~PA, 0, 0, 1'b1);
      idle();
      chk("R5 update cleared", {47'h0, cs_update}, 48'h0);
      frames(~PA, 1, 19, 1'b1);
      idle();
      chk("R6 partial", {8'h0, cs_bytes}, {8'h0, PA});
      chk_state("R6 partial");

      // Block C: 20-bit max, code 2 -> 18 bits, no de-emphasis
      frames(PC, 0, 44, 1'b1);
      idle();
      chk_state("R2 block C");
      chk("R7 deemph 011", {47'h0, deemph_en}, 48'h0);
      chk("R8 mask 18", {24'h0, wl_mask}, {24'h0, 24'hFFFFC0});

      // Block D: reserved code 3
      frames(PD, 0, 44, 1'b1);
      idle();
      chk_state("R2 block D");
      chk("R9 reserved", {24'h0, wl_mask}, {24'h0, 24'hFFFFFF});

      // Block E: 20-bit max, code 5 -> 20
      frames(PE, 0, 44, 1'b1);
      idle();
      chk_state("R2 block E");
      chk("R8 mask max20", {24'h0, wl_mask}, {24'h0, 24'hFFFFF0});
      chk("R7 deemph E", {47'h0, deemph_en}, 48'h1);

      // Block F: 24-bit max, code 0 (not indicated)
      frames(PF, 0, 44, 1'b1);
      idle();
      chk_state("R2 block F");
      chk("R9 unindicated", {24'h0, wl_mask}, {24'h0, 24'hFFFFFF});

      repeat (3) @(negedge clk);
      chk("R10 queue empty", {32'h0, 16'(sb_q.size())}, 48'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule